// File: doc/BRIEF.md
# Configuration Frame Readback Engine

This block fetches one or more consecutive configuration frames through a 32-bit internal configuration port and writes every word that the port returns into a dual-port block RAM. A controller issues a one-cycle start together with an operation code, a 32-bit starting frame address and a frame count. The engine then sends a fixed command preamble to the port, turns the port around from write to read mode, and stores the returned words at ascending RAM addresses. It then releases the port and pulses a done flag.

Every readback returns one initial word and one dummy frame before the requested frames. The engine therefore asks the port for 41 x (frames + 1) + 1 words. The initial word lands at RAM address 0, the dummy frame at addresses 1 to 41, and the requested frames from address 42 upward. The port paces the transfer with its busy output. A word is taken only in a cycle where busy is low and nothing is taken otherwise. The RAM write port cannot stall, so the only back-pressure in the block is the port's own busy signal. Chip-enable and direction are sequenced so that the direction never changes while the port is selected, or in the cycle right after it was selected. This keeps the port clear of its abort behaviour.

Top module: `frame_readback_engine`

## Requirements
- R1: A readback starts only when `start` is high while the engine is idle and `op_sel` equals 3'b001. Any other `op_sel` value with `start` causes no port select, no RAM write and no done pulse.
- R2: After a start the engine writes exactly 11 command words, one per cycle, with `cfg_ce_n`=0 and `cfg_rnw`=0. In order they are: FFFFFFFF, AA995566, 20000000, 30008001, 00000004, 20000000, 30002001, the latched frame address, 28006000, 48000000 OR word-count, 20000000.
- R3: The word count in bits 26:0 of the tenth command word is 41 x (N + 1) + 1, where N is the frame count. A frame count of 0 is treated as 1.
- R4: `cfg_rnw` is 0 for writing and 1 for reading. It changes only in a cycle where `cfg_ce_n` is high in that cycle and was high in the previous cycle.
- R5: While reading, a port word is taken only in a cycle with `cfg_busy` low. Each taken word is written to RAM one cycle later, at addresses 0, 1, 2, and so on. Exactly the word count of R3 is written, and words shown while busy is high are never stored.
- R6: RAM address 0 holds the first returned word (the initial word), and addresses 1 to 41 hold the dummy frame. The first word of the requested frames is at address 42.
- R7: `done` is a single-cycle pulse. It comes after the last RAM write, and `cfg_ce_n` is high both in the done cycle and in the cycle before it.
- R8: A start that arrives while a readback is in progress is ignored. It sends no second preamble, writes no extra RAM words and gives no extra done pulse.
- R9: In reset and after each done pulse the outputs are: `cfg_ce_n`=1, `cfg_rnw`=0, `done`=0 and `ram_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, sampled while idle |
| op_sel | input | 3 | Operation code; 3'b001 selects readback |
| frame_addr | input | 32 | Address of the first frame, latched at start |
| frame_cnt | input | CNT_W | Number of frames to read (0 treated as 1) |
| cfg_ce_n | output | 1 | Port chip-enable, active low |
| cfg_rnw | output | 1 | Port direction: 1 read, 0 write |
| cfg_din | output | 32 | Command word to the port |
| cfg_dout | input | 32 | Word returned by the port |
| cfg_busy | input | 1 | Port busy; returned word is valid only while low |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | AW | RAM write address |
| ram_wdata | output | 32 | RAM write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong preamble index or a bad latched address shows up in the command words seen by the port within the first 11 cycles after start. A wrong word-count register shows up in the tenth command word, and later as too many or too few RAM writes. A beat counter that moves while busy is high puts a garbage word, or a skipped index, into RAM on the very next write. The RAM image checked after each run exposes this. A state machine that leaves the read state or the turnaround states in the wrong order changes the direction line while the port is selected. The port model flags this on the same edge. A stuck or repeated done shows up one cycle after the pulse.

// File: rtl/frb_pkg.sv
package frb_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_WR_OFF, S_TURN_RD, S_READ, S_RD_OFF, S_TURN_WR, S_DONE
  } frb_state_e;

  localparam logic [2:0]  OP_READBACK  = 3'b001;
  localparam int          N_CMD        = 11;
  localparam int          WC_BITS      = 27;

  localparam logic [31:0] W_PAD        = 32'hFFFF_FFFF;
  localparam logic [31:0] W_SYNC       = 32'hAA99_5566;
  localparam logic [31:0] W_NOOP       = 32'h2000_0000;
  localparam logic [31:0] W_HDR_CMD    = 32'h3000_8001;
  localparam logic [31:0] W_CMD_RDCFG  = 32'h0000_0004;
  localparam logic [31:0] W_HDR_ADDR   = 32'h3000_2001;
  localparam logic [31:0] W_HDR_RDOUT  = 32'h2800_6000;
  localparam logic [31:0] W_HDR_LONG   = 32'h4800_0000;

  function automatic logic [31:0] cmd_word(input int idx,
                                           input logic [31:0] faddr,
                                           input logic [WC_BITS-1:0] wc);
    case (idx)
      0:       return W_PAD;
      1:       return W_SYNC;
      2:       return W_NOOP;
      3:       return W_HDR_CMD;
      4:       return W_CMD_RDCFG;
      5:       return W_NOOP;
      6:       return W_HDR_ADDR;
      7:       return faddr;
      8:       return W_HDR_RDOUT;
      9:       return W_HDR_LONG | {{(32-WC_BITS){1'b0}}, wc};
      default: return W_NOOP;
    endcase
  endfunction

endpackage

// File: rtl/frb_counter.sv
module frb_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= q + W'(1);
  end
endmodule

// File: rtl/frb_len_calc.sv
module frb_len_calc #(
  parameter int CNT_W       = 6,
  parameter int FRAME_WORDS = 41,
  parameter int TW          = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] frame_cnt,
  output logic [TW-1:0]    total_q
);
  logic [CNT_W-1:0] n_eff;
  logic [TW-1:0]    total_d;

  always_comb begin
    n_eff   = (frame_cnt == '0) ? CNT_W'(1) : frame_cnt;
    total_d = TW'(FRAME_WORDS) * (TW'(n_eff) + TW'(1)) + TW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    total_q <= '0;
    else if (load) total_q <= total_d;
  end
endmodule

// File: rtl/frb_cmd_seq.sv
module frb_cmd_seq #(
  parameter int IW = 4
) (
  input  logic [IW-1:0]               idx,
  input  logic [31:0]                 faddr,
  input  logic [frb_pkg::WC_BITS-1:0] wc,
  output logic [31:0]                 word
);
  logic [31:0] tbl [frb_pkg::N_CMD];

  for (genvar g = 0; g < frb_pkg::N_CMD; g++) begin : g_tbl
    assign tbl[g] = frb_pkg::cmd_word(g, faddr, wc);
  end

  always_comb begin
    word = frb_pkg::W_NOOP;
    for (int i = 0; i < frb_pkg::N_CMD; i++)
      if (idx == IW'(i)) word = tbl[i];
  end
endmodule

// File: rtl/frb_ctrl.sv
module frb_ctrl
  import frb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] op_sel,
  input  logic       cfg_busy,
  input  logic       cmd_last,
  input  logic       beat_last,
  output logic       load,
  output logic       idx_inc,
  output logic       beat_inc,
  output logic       drive_cmd,
  output logic       accept,
  output logic       ce_n,
  output logic       rnw,
  output logic       done
);
  frb_state_e st, st_n;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_n;
  end

  always_comb begin
    st_n      = st;
    load      = 1'b0;
    idx_inc   = 1'b0;
    beat_inc  = 1'b0;
    drive_cmd = 1'b0;
    accept    = 1'b0;
    ce_n      = 1'b1;
    rnw       = 1'b0;
    done      = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (start && op_sel == OP_READBACK) begin
          load = 1'b1;
          st_n = S_CMD;
        end
      end
      S_CMD: begin
        ce_n      = 1'b0;
        drive_cmd = 1'b1;
        idx_inc   = 1'b1;
        if (cmd_last) st_n = S_WR_OFF;
      end
      S_WR_OFF:  st_n = S_TURN_RD;
      S_TURN_RD: begin
        rnw  = 1'b1;
        st_n = S_READ;
      end
      S_READ: begin
        ce_n = 1'b0;
        rnw  = 1'b1;
        if (!cfg_busy) begin
          accept   = 1'b1;
          beat_inc = 1'b1;
          if (beat_last) st_n = S_RD_OFF;
        end
      end
      S_RD_OFF: begin
        rnw  = 1'b1;
        st_n = S_TURN_WR;
      end
      S_TURN_WR: st_n = S_DONE;
      S_DONE: begin
        done = 1'b1;
        st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end
endmodule

// File: rtl/frame_readback_engine.sv
module frame_readback_engine #(
  parameter  int FRAME_WORDS = 41,
  parameter  int CNT_W       = 6,
  localparam int MAX_WORDS   = FRAME_WORDS * (1 << CNT_W) + 1,
  localparam int AW          = $clog2(MAX_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op_sel,
  input  logic [31:0]      frame_addr,
  input  logic [CNT_W-1:0] frame_cnt,
  output logic             cfg_ce_n,
  output logic             cfg_rnw,
  output logic [31:0]      cfg_din,
  input  logic [31:0]      cfg_dout,
  input  logic             cfg_busy,
  output logic             ram_we,
  output logic [AW-1:0]    ram_addr,
  output logic [31:0]      ram_wdata,
  output logic             done
);
  localparam int IW = $clog2(frb_pkg::N_CMD);

  logic          load, idx_inc, beat_inc, drive_cmd, accept;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] beat_q, total_q;
  logic [31:0]   faddr_q, cmd_w;
  logic          cmd_last, beat_last;

  frb_ctrl u_ctrl (
    .clk, .rst_n, .start, .op_sel, .cfg_busy,
    .cmd_last, .beat_last,
    .load, .idx_inc, .beat_inc, .drive_cmd, .accept,
    .ce_n(cfg_ce_n), .rnw(cfg_rnw), .done
  );

  frb_counter #(.W(IW)) u_idx (
    .clk, .rst_n, .clr(load), .inc(idx_inc), .q(idx_q)
  );

  frb_counter #(.W(AW)) u_beat (
    .clk, .rst_n, .clr(load), .inc(beat_inc), .q(beat_q)
  );

  frb_len_calc #(.CNT_W(CNT_W), .FRAME_WORDS(FRAME_WORDS), .TW(AW)) u_len (
    .clk, .rst_n, .load, .frame_cnt, .total_q
  );

  frb_cmd_seq #(.IW(IW)) u_cmd (
    .idx(idx_q), .faddr(faddr_q),
    .wc(frb_pkg::WC_BITS'(total_q)), .word(cmd_w)
  );

  assign cmd_last  = (idx_q == IW'(frb_pkg::N_CMD - 1));
  assign beat_last = (beat_q == total_q - AW'(1));
  assign cfg_din   = drive_cmd ? cmd_w : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      faddr_q   <= '0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      if (load) faddr_q <= frame_addr;
      ram_we <= accept;
      if (accept) begin
        ram_addr  <= beat_q;
        ram_wdata <= cfg_dout;
      end
    end
  end
endmodule

// File: rtl/frb_checker.sv
module frb_checker #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_ce_n,
  input logic          cfg_rnw,
  input logic          cfg_busy,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic          done
);
  logic [AW-1:0] exp_addr;

  always_ff @(posedge clk) begin
    if (!rst_n)      exp_addr <= '0;
    else if (done)   exp_addr <= '0;
    else if (ram_we) exp_addr <= exp_addr + AW'(1);
  end

  p_dir_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_rnw) |-> (cfg_ce_n && $past(cfg_ce_n)));

  p_store_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(!cfg_busy && !cfg_ce_n && cfg_rnw));

  p_addr_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr == exp_addr));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cfg_ce_n && $past(cfg_ce_n) && !ram_we));

  p_idle_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cfg_ce_n && !cfg_rnw && !ram_we));
endmodule

bind frame_readback_engine frb_checker #(.AW(AW)) u_frb_checker (
  .clk, .rst_n, .cfg_ce_n, .cfg_rnw, .cfg_busy, .ram_we, .ram_addr, .done
);

// File: tb/frame_readback_engine_tb_top.sv
`timescale 1ns/1ps
module frame_readback_engine_tb_top;
  localparam int CNT_W = 6;
  localparam int AW    = $clog2(41 * (1 << CNT_W) + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] op_sel = 3'b000;
  logic [31:0] frame_addr = '0;
  logic [CNT_W-1:0] frame_cnt = '0;
  logic cfg_ce_n, cfg_rnw, ram_we, done;
  logic [31:0] cfg_din, ram_wdata;
  logic [31:0] cfg_dout = 32'hDEAD_BEEF;
  logic cfg_busy = 1'b1;
  logic [AW-1:0] ram_addr;

  always #2 clk = ~clk;

  frame_readback_engine #(.CNT_W(CNT_W)) dut_i (
    .clk, .rst_n, .start, .op_sel, .frame_addr, .frame_cnt,
    .cfg_ce_n, .cfg_rnw, .cfg_din, .cfg_dout, .cfg_busy,
    .ram_we, .ram_addr, .ram_wdata, .done
  );

  // port model and monitors
  logic [7:0]  m_lat = 8'd1, m_stall = 8'd0, m_tag = 8'd0;
  int          m_rd_cyc = 0, m_idx = 0, m_cyc = 0;
  logic [31:0] cmd_log [0:31];
  int          cmd_n = 0, aborts = 0, wr_n = 0, done_n = 0, done_wide = 0, done_bad = 0;
  logic [31:0] ram_mem [0:(1<<AW)-1];
  logic        prev_ce_n = 1'b1, prev_rnw = 1'b0, prev_done = 1'b0;
  int          n_checks = 0, n_errors = 0;

  always @(posedge clk) begin
    m_cyc <= m_cyc + 1;
    if (!cfg_ce_n && cfg_rnw) begin
      m_rd_cyc <= m_rd_cyc + 1;
      if (m_rd_cyc >= int'(m_lat) && !m_stall[m_cyc % 8]) begin
        cfg_busy <= 1'b0;
        cfg_dout <= {8'hA5, m_tag, m_idx[15:0]};
        m_idx    <= m_idx + 1;
      end else begin
        cfg_busy <= 1'b1;
        cfg_dout <= 32'hDEAD_BEEF;
      end
    end else begin
      m_rd_cyc <= 0;
      cfg_busy <= 1'b1;
      cfg_dout <= 32'hDEAD_BEEF;
    end
    if (rst_n) begin
      if (!cfg_ce_n && !cfg_rnw && cmd_n < 32) begin
        cmd_log[cmd_n] <= cfg_din;
        cmd_n <= cmd_n + 1;
      end
      if (cfg_rnw != prev_rnw && (!cfg_ce_n || !prev_ce_n)) aborts <= aborts + 1;
      if (ram_we) begin
        ram_mem[ram_addr] <= ram_wdata;
        wr_n <= wr_n + 1;
      end
      if (done) begin
        done_n <= done_n + 1;
        if (prev_done) done_wide <= done_wide + 1;
        if (!cfg_ce_n || !prev_ce_n) done_bad <= done_bad + 1;
      end
    end
    prev_ce_n <= cfg_ce_n;
    prev_rnw  <= cfg_rnw;
    prev_done <= done;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_cmd(input int i, input logic [31:0] a, input int wc);
    case (i)
      0: return 32'hFFFF_FFFF;  1: return 32'hAA99_5566;
      2: return 32'h2000_0000;  3: return 32'h3000_8001;
      4: return 32'h0000_0004;  5: return 32'h2000_0000;
      6: return 32'h3000_2001;  7: return a;
      8: return 32'h2800_6000;  9: return 32'h4800_0000 | 32'(wc);
      default: return 32'h2000_0000;
    endcase
  endfunction

  task automatic clear_logs;
    @(negedge clk);
    cmd_n = 0; wr_n = 0; done_n = 0; done_wide = 0; done_bad = 0; m_idx = 0; aborts = 0;
  endtask

  task automatic run_op(input logic [2:0] op, input int cnt, input logic [31:0] addr,
                        input logic [7:0] stall, input logic [7:0] lat, input int wait_max);
    clear_logs();
    m_stall = stall; m_lat = lat; m_tag = addr[7:0];
    op_sel = op; frame_addr = addr; frame_cnt = CNT_W'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < wait_max && done_n == 0; c++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic verify_op(input int cnt, input logic [31:0] addr, input string tag);
    int n_eff, total, bad;
    n_eff = (cnt == 0) ? 1 : cnt;
    total = 41 * (n_eff + 1) + 1;
    check(cmd_n == 11, {"R2 cmd count ", tag}, cmd_n, 11);
    bad = 0;
    for (int i = 0; i < 11; i++) if (cmd_log[i] !== exp_cmd(i, addr, total)) bad++;
    check(bad == 0, {"R2 cmd words ", tag}, bad, 0);
    check(cmd_log[9][26:0] == 27'(total), {"R3 word count ", tag}, cmd_log[9][26:0], total);
    check(wr_n == total, {"R5 ram writes ", tag}, wr_n, total);
    bad = 0;
    for (int k = 0; k < total; k++) if (ram_mem[k] !== {8'hA5, addr[7:0], 16'(k)}) bad++;
    check(bad == 0, {"R5 ram image ", tag}, bad, 0);
    check(ram_mem[0] === {8'hA5, addr[7:0], 16'd0} && ram_mem[42] === {8'hA5, addr[7:0], 16'd42},
          {"R6 layout ", tag}, ram_mem[42], {8'hA5, addr[7:0], 16'd42});
    check(aborts == 0, {"R4 dir/ce ", tag}, aborts, 0);
    check(done_n == 1 && done_wide == 0 && done_bad == 0, {"R7 done ", tag}, done_n, 1);
    check(cfg_ce_n && !cfg_rnw && !done && !ram_we, {"R9 idle ", tag},
          {cfg_ce_n, cfg_rnw, done, ram_we}, 4'b1000);
  endtask

  // {lat, cnt, stall, addr}
  localparam logic [55:0] VEC [0:3] = '{
    {8'd2, 8'd1, 8'h00, 32'h0040_0A01},
    {8'd5, 8'd2, 8'h24, 32'h0082_1302},
    {8'd1, 8'd3, 8'hAA, 32'h0021_0C1E},
    {8'd3, 8'd4, 8'h81, 32'h00C0_0033}
  };

  initial begin
    #(4 * 190000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cfg_ce_n && !cfg_rnw && !done && !ram_we, "R9 reset state",
          {cfg_ce_n, cfg_rnw, done, ram_we}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[v]) begin
      run_op(3'b001, int'(VEC[v][47:40]), VEC[v][31:0], VEC[v][39:32], VEC[v][55:48], 5000);
      verify_op(int'(VEC[v][47:40]), VEC[v][31:0], $sformatf("vec%0d", v));
    end

    // R1: other operation codes start nothing
    for (int op = 0; op < 8; op++) begin
      if (op == 1) continue;
      run_op(3'(op), 1, 32'h0000_0055, 8'h00, 8'd1, 40);
      check(cmd_n == 0 && wr_n == 0 && done_n == 0 && cfg_ce_n, $sformatf("R1 op %0d", op),
            cmd_n + wr_n + done_n, 0);
    end

    // R3: frame count 0 treated as 1
    run_op(3'b001, 0, 32'h0001_0077, 8'h10, 8'd2, 5000);
    verify_op(0, 32'h0001_0077, "cnt0");

    // R3 boundary: largest frame count
    run_op(3'b001, (1 << CNT_W) - 1, 32'h0003_0099, 8'h00, 8'd1, 8000);
    verify_op((1 << CNT_W) - 1, 32'h0003_0099, "cntmax");

    // R8: start during an active readback is ignored
    clear_logs();
    m_stall = 8'h00; m_lat = 8'd2; m_tag = 8'h11;
    op_sel = 3'b001; frame_addr = 32'h0000_0011; frame_cnt = 1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    frame_addr = 32'h0000_00EE; frame_cnt = 5; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 5000 && done_n == 0; c++) @(negedge clk);
    repeat (40) @(negedge clk);
    check(cmd_n == 11 && cmd_log[7] == 32'h0000_0011, "R8 one preamble", cmd_n, 11);
    check(wr_n == 83 && done_n == 1, "R8 no extra run", wr_n, 83);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule